// File: doc/BRIEF.md
# Boot-Selectable Memory Remap Decoder

This block decides which memory region answers a CPU address and what offset that region sees. A single configuration register drives the decision. The register holds three controls: an alias mode that picks what appears in the low window starting at address zero, a bank-exchange bit that swaps the two internal flash banks, and an external-window exchange field that moves the two SDRAM banks into the windows normally used by the NAND and PC-card regions, and moves those two regions up in return.

The alias mode is loaded from two strap inputs while reset is held. Software can rewrite it later through a plain write/read port. The strap inputs can reach only main flash, system flash or SRAM. The two external targets, NOR and SDRAM, can be placed at address zero only by a software write. Writes that carry a reserved code are dropped entirely.

The decode path is combinational from the current register value. It produces a one-hot region select, a translated local offset and a decode-error flag. The register is set up by a single master, and a region controller or fabric consumes the select and the offset.

Top module: `memRemapDecoder`

## Requirements
- R1: While `rstN` is low, the alias mode is loaded from `bootSel` and both swap controls are cleared. `bootSel` 01 gives system flash (code 001), 11 gives SRAM (code 011), and 00 or 10 gives main flash (code 000). After reset the mode is never NOR (010) or SDRAM (100).
- R2: `rdData` returns the alias mode in bits 2:0, the bank-exchange bit in bit 8 and the external-exchange field in bits 11:10. Every other bit reads as zero, whatever was written to it.
- R3: A write whose alias code is 101, 110 or 111, or whose external-exchange code is 10 or 11, is ignored as a whole. All three fields keep their previous values.
- R4: A legal write with `wrEn` high at a clock edge changes the decode seen from that edge onward, so it applies in the very next cycle.
- R5: The low alias window spans 2×2^BANK_LOG2 bytes from address 0. In main-flash mode (000), its lower half maps to the bank currently at 0x0800_0000 and its upper half maps to the bank at 0x0800_0000 + 2^BANK_LOG2. The offset is the address modulo 2^BANK_LOG2.
- R6: The native flash window at 0x0800_0000 holds two banks of 2^BANK_LOG2 bytes each. With the bank-exchange bit at 0, bank 1 is at the lower position and bank 2 at the upper one. With the bit at 1, the two banks trade places. The same exchange applies in the alias window.
- R7: In system-flash (001) or SRAM (011) alias mode, an alias address selects that target only if it is below 2^SYS_LOG2 or 2^SRAM_LOG2 respectively. Any higher address in the alias window is a decode error.
- R8: In NOR (010) or SDRAM (100) alias mode, the whole alias window selects NOR or SDRAM bank 1, with the offset equal to the address.
- R9: System flash answers natively at 0x1FFF_0000 (2^SYS_LOG2 bytes), SRAM at 0x2000_0000 (2^SRAM_LOG2 bytes) and NOR at 0x6000_0000 (256 MB). Each offset is taken relative to the region base.
- R10: External windows are 256 MB each. With exchange code 00, NAND is at 0x8000_0000, PC-card at 0x9000_0000, SDRAM1 at 0xC000_0000 and SDRAM2 at 0xD000_0000. With code 01, SDRAM1 and SDRAM2 answer at 0x8000_0000 and 0x9000_0000, and NAND and PC-card answer at 0xC000_0000 and 0xD000_0000.
- R11: An address in no region raises `decErr` with `regionSel` all zero and `localOffset` zero. Otherwise exactly one `regionSel` bit is set.
- R12: The `regionSel` bit positions are: 0 flash bank 1, 1 flash bank 2, 2 system flash, 3 SRAM, 4 NOR, 5 NAND, 6 PC-card, 7 SDRAM bank 1, 8 SDRAM bank 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset; loads the strap mode |
| bootSel | input | 2 | Strap inputs choosing the reset alias mode |
| wrEn | input | 1 | Register write strobe |
| wrData | input | REG_W | Register write value |
| rdData | output | REG_W | Current register value, unused bits zero |
| cpuAddr | input | 32 | Address to decode |
| regionSel | output | 9 | One-hot responding region |
| localOffset | output | 32 | Offset within the responding region |
| decErr | output | 1 | No region responds |

## Verification
The embedded assertions check several properties on every cycle. The register must never hold a reserved alias or exchange code. A rejected write must leave the read value unchanged, and an accepted write must appear in the next cycle. The decode must produce either exactly one select or an error with a zero select and zero offset. Flash offsets must stay inside one bank. Only the directed scenarios can show that each address lands on the right region with the right offset. These scenarios cover strap loading, the two exchange controls, the alias-window size limits and the unused register bits.

// File: rtl/remapPkg.sv
package remapPkg;
  localparam int ADDR_W = 32;
  localparam int NUM_TGT = 9;
  localparam int MODE_W = 3;
  localparam int NUM_MODES = 5;

  localparam int TGT_FLASH1 = 0;
  localparam int TGT_FLASH2 = 1;
  localparam int TGT_SYSFL  = 2;
  localparam int TGT_SRAM   = 3;
  localparam int TGT_NOR    = 4;
  localparam int TGT_NAND   = 5;
  localparam int TGT_PCCARD = 6;
  localparam int TGT_SDRAM1 = 7;
  localparam int TGT_SDRAM2 = 8;

  localparam int MODE_LSB = 0;
  localparam int BANK_SWAP_BIT = 8;
  localparam int EXT_LSB = 10;

  localparam logic [MODE_W-1:0] MODE_MAIN  = 3'd0;
  localparam logic [MODE_W-1:0] MODE_SYS   = 3'd1;
  localparam logic [MODE_W-1:0] MODE_NOR   = 3'd2;
  localparam logic [MODE_W-1:0] MODE_SRAM  = 3'd3;
  localparam logic [MODE_W-1:0] MODE_SDRAM = 3'd4;

  localparam logic [ADDR_W-1:0] FLASH_BASE = 32'h0800_0000;
  localparam logic [ADDR_W-1:0] SYS_BASE   = 32'h1FFF_0000;
  localparam logic [ADDR_W-1:0] SRAM_BASE  = 32'h2000_0000;
  localparam int EXT_LOG2 = 28;

  typedef struct packed {
    logic [NUM_MODES-1:0] aliasHot;
    logic                 bankSwap;
    logic                 extSwap;
  } remapStrobe_t;
endpackage

// File: rtl/remapCtrl.sv
module remapCtrl
  import remapPkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       bootSel,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  output remapStrobe_t     strobe
);
  logic [MODE_W-1:0] aliasMode;
  logic              bankSwap;
  logic [1:0]        extSwap;
  logic [MODE_W-1:0] bootMode;
  logic [MODE_W-1:0] wrMode;
  logic [1:0]        wrExt;
  logic              wrLegal;

  assign wrMode  = wrData[MODE_LSB +: MODE_W];
  assign wrExt   = wrData[EXT_LSB +: 2];
  assign wrLegal = (wrMode <= MODE_SDRAM) && !wrExt[1];

  always_comb begin
    unique case (bootSel)
      2'b01:   bootMode = MODE_SYS;
      2'b11:   bootMode = MODE_SRAM;
      default: bootMode = MODE_MAIN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aliasMode <= bootMode;
      bankSwap  <= 1'b0;
      extSwap   <= 2'b00;
    end else if (wrEn && wrLegal) begin
      aliasMode <= wrMode;
      bankSwap  <= wrData[BANK_SWAP_BIT];
      extSwap   <= wrExt;
    end
  end

  always_comb begin
    rdData = '0;
    rdData[MODE_LSB +: MODE_W] = aliasMode;
    rdData[BANK_SWAP_BIT]      = bankSwap;
    rdData[EXT_LSB +: 2]       = extSwap;
  end

  assign strobe.aliasHot = NUM_MODES'(1) << aliasMode;
  assign strobe.bankSwap = bankSwap;
  assign strobe.extSwap  = extSwap[0];

  // R3: the held codes are always legal ones
  a_r3_no_reserved_code: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[MODE_LSB +: MODE_W] <= MODE_SDRAM) && !rdData[EXT_LSB + 1]);
  // R3: a rejected write leaves the register untouched
  a_r3_reject_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && ((wrData[2:0] > 3'd4) || wrData[11])) |=> $stable(rdData));
  // R4: an accepted write shows one cycle later
  a_r4_write_lands: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[2:0] <= 3'd4 && !wrData[11]) |=>
      (rdData[11:0] == ($past(wrData[11:0]) & 12'hD07)));
  // R1: strap load never picks an external target
  a_r1_boot_internal: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (rdData[2:0] != MODE_NOR && rdData[2:0] != MODE_SDRAM
                     && rdData[11:8] == 4'h0));
  // R2: unused bits always read zero
  a_r2_unused_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdData & ~REG_W'(32'h0000_0D07)) == '0);
endmodule

// File: rtl/remapDatapath.sv
module remapDatapath
  import remapPkg::*;
#(
  parameter int BANK_LOG2 = 20,
  parameter int SYS_LOG2  = 15,
  parameter int SRAM_LOG2 = 17
) (
  input  logic               clk,
  input  logic               rstN,
  input  remapStrobe_t       strobe,
  input  logic [ADDR_W-1:0]  cpuAddr,
  output logic [NUM_TGT-1:0] regionSel,
  output logic [ADDR_W-1:0]  localOffset,
  output logic               decErr
);
  localparam int ALIAS_LOG2 = BANK_LOG2 + 1;
  localparam logic [ADDR_W-1:0] BANK_MASK = (ADDR_W'(1) << BANK_LOG2) - ADDR_W'(1);
  localparam logic [ADDR_W-1:0] SYS_MASK  = (ADDR_W'(1) << SYS_LOG2) - ADDR_W'(1);
  localparam logic [ADDR_W-1:0] SRAM_MASK = (ADDR_W'(1) << SRAM_LOG2) - ADDR_W'(1);
  localparam logic [ADDR_W-1:0] EXT_MASK  = (ADDR_W'(1) << EXT_LOG2) - ADDR_W'(1);

  logic [NUM_TGT-1:0] hit;
  logic [ADDR_W-1:0]  off;
  logic               upperBank;

  assign upperBank = cpuAddr[BANK_LOG2] ^ strobe.bankSwap;

  always_comb begin
    hit = '0;
    off = '0;
    if ((cpuAddr >> ALIAS_LOG2) == '0) begin
      if (strobe.aliasHot[MODE_MAIN]) begin
        hit[upperBank ? TGT_FLASH2 : TGT_FLASH1] = 1'b1;
        off = cpuAddr & BANK_MASK;
      end else if (strobe.aliasHot[MODE_SYS]) begin
        if ((cpuAddr >> SYS_LOG2) == '0) begin
          hit[TGT_SYSFL] = 1'b1;
          off = cpuAddr;
        end
      end else if (strobe.aliasHot[MODE_SRAM]) begin
        if ((cpuAddr >> SRAM_LOG2) == '0) begin
          hit[TGT_SRAM] = 1'b1;
          off = cpuAddr;
        end
      end else if (strobe.aliasHot[MODE_NOR]) begin
        hit[TGT_NOR] = 1'b1;
        off = cpuAddr;
      end else if (strobe.aliasHot[MODE_SDRAM]) begin
        hit[TGT_SDRAM1] = 1'b1;
        off = cpuAddr;
      end
    end else if ((cpuAddr >> ALIAS_LOG2) == (FLASH_BASE >> ALIAS_LOG2)) begin
      hit[upperBank ? TGT_FLASH2 : TGT_FLASH1] = 1'b1;
      off = cpuAddr & BANK_MASK;
    end else if ((cpuAddr >> SYS_LOG2) == (SYS_BASE >> SYS_LOG2)) begin
      hit[TGT_SYSFL] = 1'b1;
      off = cpuAddr & SYS_MASK;
    end else if ((cpuAddr >> SRAM_LOG2) == (SRAM_BASE >> SRAM_LOG2)) begin
      hit[TGT_SRAM] = 1'b1;
      off = cpuAddr & SRAM_MASK;
    end else begin
      off = cpuAddr & EXT_MASK;
      unique case (cpuAddr[ADDR_W-1:EXT_LOG2])
        4'h6: hit[TGT_NOR] = 1'b1;
        4'h8: hit[strobe.extSwap ? TGT_SDRAM1 : TGT_NAND]   = 1'b1;
        4'h9: hit[strobe.extSwap ? TGT_SDRAM2 : TGT_PCCARD] = 1'b1;
        4'hC: hit[strobe.extSwap ? TGT_NAND   : TGT_SDRAM1] = 1'b1;
        4'hD: hit[strobe.extSwap ? TGT_PCCARD : TGT_SDRAM2] = 1'b1;
        default: off = '0;
      endcase
    end
  end

  assign regionSel   = hit;
  assign decErr      = (hit == '0);
  assign localOffset = decErr ? '0 : off;

  // R11: a successful decode names exactly one region
  a_r11_one_target: assert property (@(posedge clk) disable iff (!rstN)
    !decErr |-> $onehot(regionSel));
  // R11: an error carries neither select nor offset
  a_r11_err_quiet: assert property (@(posedge clk) disable iff (!rstN)
    decErr |-> (regionSel == '0 && localOffset == '0));
  // R5/R6: flash offsets stay inside one bank
  a_r6_bank_bound: assert property (@(posedge clk) disable iff (!rstN)
    (regionSel[TGT_FLASH1] || regionSel[TGT_FLASH2]) |-> (localOffset <= BANK_MASK));
  // R10: external targets never see an offset past their window
  a_r10_ext_bound: assert property (@(posedge clk) disable iff (!rstN)
    (regionSel[TGT_NAND] || regionSel[TGT_PCCARD] || regionSel[TGT_SDRAM2])
      |-> (localOffset <= EXT_MASK));
endmodule

// File: rtl/memRemapDecoder.sv
module memRemapDecoder
  import remapPkg::*;
#(
  parameter int REG_W     = 32,
  parameter int BANK_LOG2 = 20,
  parameter int SYS_LOG2  = 15,
  parameter int SRAM_LOG2 = 17
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         bootSel,
  input  logic               wrEn,
  input  logic [REG_W-1:0]   wrData,
  output logic [REG_W-1:0]   rdData,
  input  logic [ADDR_W-1:0]  cpuAddr,
  output logic [NUM_TGT-1:0] regionSel,
  output logic [ADDR_W-1:0]  localOffset,
  output logic               decErr
);
  remapStrobe_t strobe;

  remapCtrl #(.REG_W(REG_W)) uCtrl (
    .clk(clk), .rstN(rstN), .bootSel(bootSel),
    .wrEn(wrEn), .wrData(wrData), .rdData(rdData), .strobe(strobe)
  );

  remapDatapath #(
    .BANK_LOG2(BANK_LOG2), .SYS_LOG2(SYS_LOG2), .SRAM_LOG2(SRAM_LOG2)
  ) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cpuAddr(cpuAddr),
    .regionSel(regionSel), .localOffset(localOffset), .decErr(decErr)
  );
endmodule

// File: tb/tb_memRemapDecoder.sv
module tb_memRemapDecoder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  bootSel = 2'b00;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [31:0] cpuAddr = '0;
  logic [8:0]  regionSel;
  logic [31:0] localOffset;
  logic        decErr;
  int nTests = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  memRemapDecoder dut (
    .clk(clk), .rstN(rstN), .bootSel(bootSel), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .cpuAddr(cpuAddr), .regionSel(regionSel),
    .localOffset(localOffset), .decErr(decErr)
  );

  task automatic chkReg(input logic [31:0] exp, input string req);
    nTests++;
    if (rdData !== exp) begin
      nFail++;
      $display("FAIL %s rdData actual %h expected %h", req, rdData, exp);
    end
  endtask

  // expIdx < 0 means a decode error is expected
  task automatic chkDec(input logic [31:0] addr, input int expIdx,
                        input logic [31:0] expOff, input string req);
    logic [8:0] expSel;
    @(negedge clk);
    cpuAddr = addr;
    #1;
    expSel = (expIdx < 0) ? 9'b0 : (9'b1 << expIdx);
    nTests++;
    if (regionSel !== expSel || localOffset !== ((expIdx < 0) ? 32'h0 : expOff)
        || decErr !== (expIdx < 0)) begin
      nFail++;
      $display("FAIL %s addr %h actual sel %b off %h err %b expected sel %b off %h err %b",
               req, addr, regionSel, localOffset, decErr, expSel,
               (expIdx < 0) ? 32'h0 : expOff, expIdx < 0);
    end
  endtask

  task automatic doReset(input logic [1:0] strap);
    @(negedge clk);
    rstN = 1'b0; bootSel = strap;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    #1;
  endtask

  task automatic doWrite(input logic [31:0] val);
    @(negedge clk);
    wrEn = 1'b1; wrData = val;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
    #1;
  endtask

  task automatic testBootMain;
    doReset(2'b00);
    chkReg(32'h0, "R1 strap00");
    chkDec(32'h0000_1234, 0, 32'h1234, "R5 alias low half");
    chkDec(32'h0010_0010, 1, 32'h10, "R5 alias high half");
    doReset(2'b10);
    chkReg(32'h0, "R1 strap10");
  endtask

  task automatic testBootSys;
    doReset(2'b01);
    chkReg(32'h1, "R1 strap01");
    chkDec(32'h0000_0100, 2, 32'h100, "R7 sys alias");
    chkDec(32'h0000_8000, -1, 32'h0, "R7 sys alias beyond size");
    chkDec(32'h1FFF_0040, 2, 32'h40, "R9 sys native");
  endtask

  task automatic testBootSram;
    doReset(2'b11);
    chkReg(32'h3, "R1 strap11");
    chkDec(32'h0001_FFFC, 3, 32'h1_FFFC, "R7 sram alias top");
    chkDec(32'h0002_0000, -1, 32'h0, "R7 sram alias beyond size");
    chkDec(32'h2000_0800, 3, 32'h800, "R9 sram native");
  endtask

  task automatic testFlashSwap;
    doReset(2'b00);
    chkDec(32'h0800_0004, 0, 32'h4, "R6 bank1 low");
    chkDec(32'h0810_0008, 1, 32'h8, "R6 bank2 high");
    doWrite(32'h0000_0100);
    chkReg(32'h100, "R2 bank bit");
    chkDec(32'h0800_0004, 1, 32'h4, "R6 swapped low");
    chkDec(32'h0810_0008, 0, 32'h8, "R6 swapped high");
    chkDec(32'h0000_0000, 1, 32'h0, "R6 swapped alias");
    chkDec(32'h0820_0000, -1, 32'h0, "R11 past flash");
  endtask

  task automatic testExtSwap;
    doReset(2'b00);
    chkDec(32'h8000_0010, 5, 32'h10, "R10 nand default");
    chkDec(32'hC000_0020, 7, 32'h20, "R10 sdram1 default");
    chkDec(32'hDFFF_FFFF, 8, 32'h0FFF_FFFF, "R10 sdram2 default");
    doWrite(32'h0000_0400);
    chkReg(32'h400, "R2 ext field");
    chkDec(32'h8000_0010, 7, 32'h10, "R10 sdram1 swapped");
    chkDec(32'h9000_0000, 8, 32'h0, "R10 sdram2 swapped");
    chkDec(32'hC000_0020, 5, 32'h20, "R10 nand swapped");
    chkDec(32'hD000_0004, 6, 32'h4, "R10 pccard swapped");
  endtask

  task automatic testReserved;
    doReset(2'b00);
    doWrite(32'h0000_0503);
    chkReg(32'h503, "R4 legal write");
    doWrite(32'h0000_0005);
    chkReg(32'h503, "R3 mode 101 dropped");
    doWrite(32'h0000_0807);
    chkReg(32'h503, "R3 mode 111 dropped");
    doWrite(32'h0000_0C00);
    chkReg(32'h503, "R3 ext 11 dropped");
    doWrite(32'h0000_0900);
    chkReg(32'h503, "R3 ext 10 dropped");
    chkDec(32'h0000_0040, 3, 32'h40, "R3 decode kept sram");
    chkDec(32'h8000_0000, 7, 32'h0, "R3 decode kept ext swap");
  endtask

  task automatic testFieldMask;
    doReset(2'b00);
    doWrite(32'h0000_74F2);
    chkReg(32'h402, "R2 unused bits zero");
    chkDec(32'h0000_0040, 4, 32'h40, "R8 nor alias");
    chkDec(32'h6000_1000, 4, 32'h1000, "R9 nor native");
    doWrite(32'h0000_0004);
    chkDec(32'h001F_FFF0, 7, 32'h001F_FFF0, "R8 sdram alias");
    chkDec(32'h0020_0000, -1, 32'h0, "R11 above alias");
  endtask

  task automatic testTiming;
    doReset(2'b00);
    @(negedge clk);
    cpuAddr = 32'h0000_0010;
    wrEn = 1'b1; wrData = 32'h0000_0003;
    #1;
    nTests++;
    if (regionSel !== 9'b1) begin
      nFail++;
      $display("FAIL R4 before edge actual %b expected %b", regionSel, 9'b1);
    end
    @(posedge clk);
    #1;
    wrEn = 1'b0;
    nTests++;
    if (regionSel !== 9'b1000 || localOffset !== 32'h10) begin
      nFail++;
      $display("FAIL R4 after edge actual %b/%h expected %b/%h",
               regionSel, localOffset, 9'b1000, 32'h10);
    end
  endtask

  task automatic testUnmapped;
    chkDec(32'h4000_0000, -1, 32'h0, "R11 gap");
    chkDec(32'hF000_0000, -1, 32'h0, "R11 top");
    chkDec(32'h1FFE_FFFC, -1, 32'h0, "R11 below sys");
    chkDec(32'hA000_0000, -1, 32'h0, "R12 gap in ext");
  endtask

  initial begin
    testBootMain();
    testBootSys();
    testBootSram();
    testFlashSwap();
    testExtSwap();
    testReserved();
    testFieldMask();
    testTiming();
    testUnmapped();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1'b1;
      nTests++;
      nFail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule